// File: doc/BRIEF.md
# Isochronous Stream Sequence Monitor

This block watches the packet traffic of a two-way isochronous audio link and keeps five error counters for it. Every incoming packet offers two sequence bytes: the device's own running number, and an echo of a number that the host placed in an earlier outgoing packet. The monitor follows both. It counts the numbers that the device skipped. It also counts every echo that differs from the value it expected. It counts packets that the link layer marked as corrupt. Separately, it counts overrun and underrun episodes, each from a condition level.

The counters can be read at any time. A single clear pulse sets all of them back to zero and restarts sequence tracking, so software can take a fresh measurement window. The design is purely a monitor: payload and buffering belong to the surrounding logic.

Top module: `iseq_monitor`

## Requirements
- R1: After reset, all five counters read zero.
- R2: For a good incoming packet, when the sequence tracker is armed, the missed-input counter grows by (own_seq − expected) mod 256. The expected value is then own_seq + 1 mod 256. An in-order packet adds nothing, a gap of k adds k−1, and a repeated number adds 255.
- R3: The first good incoming packet after reset or clear arms both trackers. It loads each expected value with its received byte plus one and adds to no counter.
- R4: For a good incoming packet with the mirror tracker armed, a mirror byte unequal to the expected value adds one to the missed-output counter. In every case the expected value becomes mirror + 1 mod 256, so a swapped pair of packets gives a run of misses.
- R5: A valid incoming packet with the bad flag set adds one to the bad-packet counter. It changes neither tracker: the next good packet is checked against the state that held before the bad packet.
- R6: The overrun counter adds one on each cycle where the overrun level is high and was low in the previous cycle. The counter does not change while the level stays high.
- R7: The underrun counter follows the rule of R6, using the underrun level.
- R8: A cycle with the clear input high sets all counters to zero and disarms both trackers. Events in that same cycle are discarded. The level history of R6 and R7 is kept, so an episode already in progress at the clear is not counted again.
- R9: Counters are 16 bits wide and saturate at 65535, including when one increment would pass the limit.
- R10: An event sampled at a rising clock edge is visible on the counter outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Clear pulse for counters and trackers |
| in_vld_i | input | 1 | Incoming packet present this cycle |
| in_seq_i | input | 8 | Device's own sequence byte |
| in_mirror_i | input | 8 | Echoed outgoing sequence byte |
| in_bad_i | input | 1 | Incoming packet marked corrupt |
| ovr_i | input | 1 | Input overrun condition level |
| und_i | input | 1 | Output underrun condition level |
| cnt_in_ovr_o | output | 16 | Input overrun episodes |
| cnt_in_miss_o | output | 16 | Missed input sequence numbers |
| cnt_in_bad_o | output | 16 | Bad incoming packets |
| cnt_out_und_o | output | 16 | Output underrun episodes |
| cnt_out_miss_o | output | 16 | Mirror mismatches |

## Verification
The assertions assume the following about the inputs:
- The sequence bytes are meaningful only when the valid input is high.
- The bad flag is qualified by that valid input.
- Clear is synchronous and may coincide with any other event.

The stimulus drives every input at the falling clock edge, holds it through the next rising edge, and asserts the valid input only for a packet. It covers these cases:
- in-order numbers, gaps, wrap-around and repeats;
- swapped mirror pairs;
- a corrupt packet between good packets;
- overlapping overrun and underrun episodes;
- a clear during an active episode and a clear that coincides with a packet;
- a run of repeated numbers long enough to drive a counter to its limit.

// File: rtl/iseq_pkg.sv
package iseq_pkg;
  typedef enum logic {TRK_GAP, TRK_MATCH} trk_mode_e;
  localparam int unsigned NUM_CNT  = 5;
  localparam int unsigned IDX_OVR  = 0;
  localparam int unsigned IDX_IMIS = 1;
  localparam int unsigned IDX_BAD  = 2;
  localparam int unsigned IDX_UND  = 3;
  localparam int unsigned IDX_OMIS = 4;
endpackage

// File: rtl/iseq_tracker.sv
module iseq_tracker
  import iseq_pkg::*;
#(
  parameter int unsigned SEQ_W = 8,
  parameter trk_mode_e   MODE  = TRK_GAP
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             upd_i,
  input  logic [SEQ_W-1:0] seq_i,
  output logic [SEQ_W-1:0] inc_o
);
  logic             armed_q;
  logic [SEQ_W-1:0] exp_q;
  logic             live;

  assign live = upd_i & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      exp_q   <= '0;
    end else if (clr_i) begin
      armed_q <= 1'b0;
    end else if (upd_i) begin
      armed_q <= 1'b1;
      exp_q   <= seq_i + SEQ_W'(1);
    end
  end

  generate
    if (MODE == TRK_GAP) begin : g_gap
      // modulo distance equals numbers skipped
      assign inc_o = (live && armed_q) ? (seq_i - exp_q) : '0;
    end else begin : g_match
      assign inc_o = (live && armed_q && (seq_i != exp_q)) ? SEQ_W'(1) : '0;
    end
  endgenerate

  // unarmed tracker never reports (R3)
  assert_first_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> inc_o == '0);
  assert_arm_after_update_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !clr_i) |=> armed_q);
endmodule

// File: rtl/iseq_episode.sv
module iseq_episode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic start_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign start_o = lvl_i & ~lvl_q;

  assert_one_per_episode_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
endmodule

// File: rtl/iseq_sat_counter.sv
module iseq_sat_counter #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned INC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   sum;

  assign sum = {1'b0, cnt_q} + (CNT_W+1)'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (sum[CNT_W]) cnt_q <= CNT_MAX;
    else              cnt_q <= sum[CNT_W-1:0];
  end

  assign cnt_o = cnt_q;

  assert_no_decrease_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(clr_i) |-> cnt_q >= $past(cnt_q));
  assert_step_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(clr_i) |-> ({1'b0, cnt_q} <= {1'b0, $past(cnt_q)} + (CNT_W+1)'($past(inc_i))));
  assert_clear_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) |-> cnt_q == '0);
endmodule

// File: rtl/iseq_monitor.sv
module iseq_monitor
  import iseq_pkg::*;
#(
  parameter int unsigned SEQ_W = 8,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             in_vld_i,
  input  logic [SEQ_W-1:0] in_seq_i,
  input  logic [SEQ_W-1:0] in_mirror_i,
  input  logic             in_bad_i,
  input  logic             ovr_i,
  input  logic             und_i,
  output logic [CNT_W-1:0] cnt_in_ovr_o,
  output logic [CNT_W-1:0] cnt_in_miss_o,
  output logic [CNT_W-1:0] cnt_in_bad_o,
  output logic [CNT_W-1:0] cnt_out_und_o,
  output logic [CNT_W-1:0] cnt_out_miss_o
);
  logic             good_pkt;
  logic             bad_pkt;
  logic             ovr_start, und_start;
  logic [SEQ_W-1:0] gap_inc, match_inc;
  logic [SEQ_W-1:0] inc   [NUM_CNT];
  logic [CNT_W-1:0] cnt   [NUM_CNT];

  assign good_pkt = in_vld_i & ~in_bad_i;
  assign bad_pkt  = in_vld_i &  in_bad_i;

  iseq_tracker #(.SEQ_W(SEQ_W), .MODE(TRK_GAP)) u_own_trk (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
    .upd_i (good_pkt), .seq_i(in_seq_i), .inc_o(gap_inc)
  );

  iseq_tracker #(.SEQ_W(SEQ_W), .MODE(TRK_MATCH)) u_mir_trk (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
    .upd_i (good_pkt), .seq_i(in_mirror_i), .inc_o(match_inc)
  );

  iseq_episode u_ovr_ep (.clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(ovr_i), .start_o(ovr_start));
  iseq_episode u_und_ep (.clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(und_i), .start_o(und_start));

  assign inc[IDX_OVR]  = SEQ_W'(ovr_start);
  assign inc[IDX_IMIS] = gap_inc;
  assign inc[IDX_BAD]  = SEQ_W'(bad_pkt);
  assign inc[IDX_UND]  = SEQ_W'(und_start);
  assign inc[IDX_OMIS] = match_inc;

  generate
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
      iseq_sat_counter #(.CNT_W(CNT_W), .INC_W(SEQ_W)) u_cnt (
        .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
        .inc_i (inc[g]), .cnt_o(cnt[g])
      );
    end
  endgenerate

  assign cnt_in_ovr_o   = cnt[IDX_OVR];
  assign cnt_in_miss_o  = cnt[IDX_IMIS];
  assign cnt_in_bad_o   = cnt[IDX_BAD];
  assign cnt_out_und_o  = cnt[IDX_UND];
  assign cnt_out_miss_o = cnt[IDX_OMIS];

  assert_bad_no_track_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_pkt |-> (gap_inc == '0 && match_inc == '0));
  assert_idle_no_miss_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_vld_i && !clr_i) |=> (cnt_in_miss_o == $past(cnt_in_miss_o) &&
                               cnt_out_miss_o == $past(cnt_out_miss_o)));
  assert_mirror_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_out_miss_o - $past(cnt_out_miss_o)) <= CNT_W'(1));
  assert_level_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (und_i && $past(und_i) && !clr_i) |=> $stable(cnt_out_und_o));
endmodule

// File: tb/iseq_monitor_tb.sv
module iseq_monitor_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, vld = 1'b0, bad = 1'b0, ovr = 1'b0, und = 1'b0;
  logic [7:0] seq = '0, mir = '0;
  logic [15:0] c_ovr, c_imis, c_bad, c_und, c_omis;

  always #10 clk = ~clk;

  iseq_monitor u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .in_vld_i(vld), .in_seq_i(seq),
    .in_mirror_i(mir), .in_bad_i(bad), .ovr_i(ovr), .und_i(und),
    .cnt_in_ovr_o(c_ovr), .cnt_in_miss_o(c_imis), .cnt_in_bad_o(c_bad),
    .cnt_out_und_o(c_und), .cnt_out_miss_o(c_omis)
  );

  typedef struct {
    string       tag;
    logic [15:0] v [5];
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_fail = 0;

  // reference model
  int  m_cnt [5];
  bit  m_arm_own = 0, m_arm_mir = 0, m_ovr_prev = 0, m_und_prev = 0;
  logic [7:0] m_exp_own = 0, m_exp_mir = 0;

  function automatic int sat_add(int a, int b);
    return (a + b > 65535) ? 65535 : a + b;
  endfunction

  task automatic model_edge();
    bit os, us;
    os = ovr && !m_ovr_prev;
    us = und && !m_und_prev;
    m_ovr_prev = ovr;
    m_und_prev = und;
    if (clr) begin
      for (int i = 0; i < 5; i++) m_cnt[i] = 0;
      m_arm_own = 0;
      m_arm_mir = 0;
    end else begin
      if (os) m_cnt[0] = sat_add(m_cnt[0], 1);
      if (us) m_cnt[3] = sat_add(m_cnt[3], 1);
      if (vld && bad) m_cnt[2] = sat_add(m_cnt[2], 1);
      if (vld && !bad) begin
        logic [7:0] d;
        d = seq - m_exp_own;
        if (m_arm_own) m_cnt[1] = sat_add(m_cnt[1], int'(d));
        if (m_arm_mir && mir != m_exp_mir) m_cnt[4] = sat_add(m_cnt[4], 1);
        m_arm_own = 1;
        m_arm_mir = 1;
        m_exp_own = seq + 8'd1;
        m_exp_mir = mir + 8'd1;
      end
    end
  endtask

  task automatic step(bit v, logic [7:0] s, logic [7:0] m, bit b, bit o, bit u, bit c,
                      string tag);
    exp_t e;
    @(negedge clk);
    vld = v; seq = s; mir = m; bad = b; ovr = o; und = u; clr = c;
    @(posedge clk);
    model_edge();
    e.tag = tag;
    for (int i = 0; i < 5; i++) e.v[i] = 16'(m_cnt[i]);
    q.push_back(e);
  endtask

  task automatic pkt(logic [7:0] s, logic [7:0] m, string tag);
    step(1, s, m, 0, ovr, und, 0, tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      logic [15:0] act [5];
      bit bad_cmp;
      e = q.pop_front();
      act[0] = c_ovr; act[1] = c_imis; act[2] = c_bad; act[3] = c_und; act[4] = c_omis;
      bad_cmp = 0;
      for (int i = 0; i < 5; i++)
        if (act[i] !== e.v[i]) begin
          bad_cmp = 1;
          $display("FAIL %s counter%0d actual %0d expected %0d", e.tag, i, act[i], e.v[i]);
        end
      n_chk++;
      if (bad_cmp) n_fail++;
    end
  end

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 5; i++) m_cnt[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0, "R1 reset zero");
    // R3 arm, R2 in-order and gaps
    pkt(8'd10, 8'd5, "R3 first packet quiet");
    pkt(8'd11, 8'd6, "R2 in order");
    pkt(8'd15, 8'd7, "R2 gap of four");
    pkt(8'd254, 8'd8, "R2 large gap");
    pkt(8'd1, 8'd9, "R2 wrap gap");
    pkt(8'd1, 8'd10, "R2 repeated number");
    // R4 swapped mirror pair burst
    pkt(8'd2, 8'd12, "R4 mirror skip");
    pkt(8'd3, 8'd11, "R4 mirror swapped back");
    pkt(8'd4, 8'd13, "R4 mirror burst");
    pkt(8'd5, 8'd14, "R4 mirror resync");
    // R5 bad packet leaves trackers
    step(1, 8'd99, 8'd77, 1, 0, 0, 0, "R5 bad counted");
    pkt(8'd6, 8'd15, "R5 tracking intact");
    // R6 R7 episodes
    step(0, 0, 0, 0, 1, 0, 0, "R6 overrun start");
    step(0, 0, 0, 0, 1, 1, 0, "R7 underrun start");
    step(1, 8'd7, 8'd16, 0, 1, 1, 0, "R6 level held");
    step(0, 0, 0, 0, 0, 1, 0, "R6 overrun ends");
    step(0, 0, 0, 0, 1, 0, 0, "R6 second episode R7 ends");
    step(0, 0, 0, 0, 1, 1, 0, "R7 second underrun");
    // R8 clear during episode and with packet
    step(1, 8'd50, 8'd50, 0, 1, 1, 1, "R8 clear discards");
    step(0, 0, 0, 0, 1, 1, 0, "R8 episode not recounted");
    pkt(8'd40, 8'd90, "R3 first after clear");
    pkt(8'd42, 8'd92, "R2 R4 after clear");
    step(0, 0, 0, 0, 0, 0, 0, "R10 idle");
    // R9 saturation: 257 repeats of 0 adds 255 each = 65535
    step(0, 0, 0, 0, 0, 0, 1, "R8 clear before saturation");
    pkt(8'd0, 8'd0, "R3 arm for saturation");
    for (int i = 0; i < 257; i++) pkt(8'd0, 8'd1, "R9 climb");
    pkt(8'd0, 8'd1, "R9 held at limit");
    pkt(8'd200, 8'd1, "R9 held at limit again");
    step(0, 0, 0, 0, 0, 0, 0, "R9 idle");
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule